// File: doc/BRIEF.md
# Keyed-Feed Watchdog Timer

This block is a watchdog counter meant for a small controller subsystem. A free-running watchdog clock, supplied here as a one-cycle enable called `tickEn`, drives a prescaler and an 8-bit down counter. Software keeps the watchdog from firing by restarting it with a two-step key sequence. The key sequence is a fixed first byte written to one key register, followed by a fixed second byte written to another key register, with no other register write between them. If the count runs out before software restarts it, the block raises a reset request. When the block is used as a plain interval timer, it sets an overflow flag instead and can raise an interrupt.

The timeout length is set by a 3-bit prescaler selection and an 8-bit load value. The prescaler selection and the run and mode bits are written to a control register. The counter does not use that register directly; it uses a shadow copy that is refreshed on every watchdog tick. Once the reset mode has been turned on, only the power-on reset clears it. While reset mode is on, the counter cannot be stopped.

Top module: `keyed_watchdog`

## Requirements
- R1: After power-on reset, `wdReset`, `ovfFlag` and `irq` are all 0.
- R2: A restart is valid when 8'hA5 is written to key register 1 (`wrSel`=2) and the next register write is 8'h5A to key register 2 (`wrSel`=3). A valid restart reloads the counter from the load register (`wrSel`=1) and clears the prescaler. A watchdog that is restarted in time never requests a reset.
- R3: After a valid restart, the underflow happens on tick number 2^(5+PRE)·(LOAD+1)+1. PRE is control bits [6:4]. The shortest timeout is 33 ticks (PRE=0, LOAD=0).
- R4: Clock cycles with `tickEn`=0 do not advance the prescaler or the counter.
- R5: After an accepted key-1 write, any register write other than a correct key-2 write is a violation. This includes a pulse on `otherWr` and a write to the load register. In reset mode, a violation sets `wdReset` at the same clock edge.
- R6: Each of these is also a violation: a key-1 write with a value other than 8'hA5, a key-2 write with a value other than 8'h5A, and a key-2 write with no accepted key-1 write before it.
- R7: A control write takes effect at the first `tickEn` edge after the write. The counter starts using the new settings on the tick after that edge.
- R8: The reset-mode bit (control bit 1) is sticky until power-on reset. While it is set, the counter runs whatever value the run bit (control bit 0) holds.
- R9: In timer mode (bit 1 never set), an underflow sets `ovfFlag` and does not set `wdReset`. The counter then reloads and repeats the same period. `irq` equals `ovfFlag` gated by control bit 2. A control write with bit 3 set clears `ovfFlag`.
- R10: Once `wdReset` is set, it stays set until power-on reset, even if a valid restart follows.
- R11: In timer mode, key violations have no effect on `wdReset` or `ovfFlag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstPor_n | input | 1 | Power-on reset, active low, asynchronous |
| tickEn | input | 1 | Watchdog clock enable, one tick per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 control, 1 load, 2 key 1, 3 key 2 |
| wrData | input | 8 | Write data |
| otherWr | input | 1 | Strobe for a write to any register outside this block |
| wdReset | output | 1 | Sticky reset request |
| ovfFlag | output | 1 | Timer-mode underflow flag |
| irq | output | 1 | Interrupt, the overflow flag gated by its enable |

## Verification
The assertions check the following on every cycle:
- `wdReset` is sticky.
- The reset mode never drops.
- `irq` is never high without `ovfFlag`.
- A cycle without a tick cannot raise either output.
- A violation in reset mode is followed by a reset request.
- Timer mode never raises a reset.

Some behaviours can only be shown by the bench's scenarios:
- The exact timeout count for each PRE and LOAD pair.
- The one-tick delay before a control write takes effect.
- The way the key checker classifies each kind of wrong value or interleaved write.
- The periodic reload in timer mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_KEY1 = 2'd2,
    SEL_KEY2 = 2'd3
  } wdtSel_e;

  // control byte layout
  localparam int CTL_RUN     = 0;
  localparam int CTL_MODE    = 1;
  localparam int CTL_IRQEN   = 2;
  localparam int CTL_CLR     = 3;
  localparam int CTL_PRE_LSB = 4;

  // strobes from the control half to the counting half
  typedef struct packed {
    logic reload;   // valid key pair completed
    logic violate;  // broken key sequence
    logic clrFlag;  // control write asked to clear the flag
    logic step;     // counting tick
  } wdtStrobe_t;

endpackage

// File: rtl/wdt_feed_ctrl.sv
module wdt_feed_ctrl
  import wdt_pkg::*;
#(
  parameter int              DATA_W = 8,
  parameter int              PRE_W  = 3,
  parameter logic [DATA_W-1:0] KEY1 = 8'hA5,
  parameter logic [DATA_W-1:0] KEY2 = 8'h5A
) (
  input  logic              clk,
  input  logic              rstPor_n,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              otherWr,
  output wdtStrobe_t        strb,
  output logic [DATA_W-1:0] loadVal,
  output logic              resetMode,
  output logic              irqEn,
  output logic [PRE_W-1:0]  preSel
);

  localparam int PRE_MSB = CTL_PRE_LSB + PRE_W - 1;

  typedef enum logic {FEED_IDLE, FEED_ARMED} feedSt_e;

  feedSt_e           feedSt, feedNx;
  logic              ctlRun, ctlMode, ctlIrq;
  logic [PRE_W-1:0]  ctlPre;
  logic              shRun, shMode;
  logic [PRE_W-1:0]  shPre;
  logic [DATA_W-1:0] loadReg;
  logic              wrCtrl, wrLoad, wrKey1, wrKey2, anyWr;
  logic              reloadNow, violNow;
  logic              unusedBits;

  assign unusedBits = ^wrData[DATA_W-1:PRE_MSB+1];

  assign wrCtrl = wrEn && (wrSel == SEL_CTRL);
  assign wrLoad = wrEn && (wrSel == SEL_LOAD);
  assign wrKey1 = wrEn && (wrSel == SEL_KEY1);
  assign wrKey2 = wrEn && (wrSel == SEL_KEY2);
  assign anyWr  = wrEn || otherWr;

  // key sequence checker
  always_comb begin
    feedNx    = feedSt;
    reloadNow = 1'b0;
    violNow   = 1'b0;
    unique case (feedSt)
      FEED_IDLE: begin
        if (wrKey1) begin
          if (wrData == KEY1 && !otherWr) feedNx = FEED_ARMED;
          else                            violNow = 1'b1;
        end else if (wrKey2) begin
          violNow = 1'b1;
        end
      end
      FEED_ARMED: begin
        if (anyWr) begin
          feedNx = FEED_IDLE;
          if (wrKey2 && wrData == KEY2 && !otherWr) reloadNow = 1'b1;
          else                                      violNow   = 1'b1;
        end
      end
      default: feedNx = FEED_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstPor_n) begin
    if (!rstPor_n) begin
      feedSt  <= FEED_IDLE;
      ctlRun  <= 1'b0;
      ctlMode <= 1'b0;
      ctlIrq  <= 1'b0;
      ctlPre  <= '0;
      shRun   <= 1'b0;
      shMode  <= 1'b0;
      shPre   <= '0;
      loadReg <= '0;
    end else begin
      feedSt <= feedNx;
      if (wrLoad) loadReg <= wrData;
      if (wrCtrl) begin
        ctlRun  <= wrData[CTL_RUN];
        ctlMode <= ctlMode | wrData[CTL_MODE];
        ctlIrq  <= wrData[CTL_IRQEN];
        ctlPre  <= wrData[PRE_MSB:CTL_PRE_LSB];
      end
      // shadow refresh one watchdog tick after the write
      if (tickEn) begin
        shRun  <= ctlRun;
        shMode <= ctlMode;
        shPre  <= ctlPre;
      end
    end
  end

  assign strb.reload  = reloadNow;
  assign strb.violate = violNow;
  assign strb.clrFlag = wrCtrl && wrData[CTL_CLR];
  assign strb.step    = tickEn && (shRun || shMode);
  assign loadVal      = loadReg;
  assign resetMode    = shMode;
  assign irqEn        = ctlIrq;
  assign preSel       = shPre;

endmodule

// File: rtl/wdt_count_path.sv
module wdt_count_path
  import wdt_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int PRE_W    = 3,
  parameter int FIX_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rstPor_n,
  input  wdtStrobe_t        strb,
  input  logic [DATA_W-1:0] loadVal,
  input  logic              resetMode,
  input  logic              irqEn,
  input  logic [PRE_W-1:0]  preSel,
  output logic              wdReset,
  output logic              ovfFlag,
  output logic              irq
);

  localparam int PRE_MAX = (1 << PRE_W) - 1;
  localparam int PS_W    = FIX_LOG2 + PRE_MAX;

  logic [PS_W-1:0]   psCnt, psMask;
  logic [PRE_W-1:0]  shAmt;
  logic              psTerm;
  logic [DATA_W-1:0] cnt;
  logic              expire;
  logic              underflow;

  // prescaler length 2^(FIX_LOG2+preSel)
  assign shAmt     = PRE_W'(PRE_MAX) - preSel;
  assign psMask    = {PS_W{1'b1}} >> shAmt;
  assign psTerm    = &(psCnt | ~psMask);
  assign underflow = strb.step && expire && !strb.reload;

  always_ff @(posedge clk or negedge rstPor_n) begin
    if (!rstPor_n) begin
      psCnt   <= '0;
      cnt     <= '0;
      expire  <= 1'b0;
      wdReset <= 1'b0;
      ovfFlag <= 1'b0;
    end else begin
      if (strb.reload) begin
        psCnt  <= '0;
        cnt    <= loadVal;
        expire <= 1'b0;
      end else if (strb.step) begin
        if (expire) begin
          expire <= 1'b0;
          psCnt  <= '0;
          cnt    <= loadVal;
        end else if (psTerm) begin
          psCnt <= '0;
          if (cnt == '0) expire <= 1'b1;
          else           cnt    <= cnt - 1'b1;
        end else begin
          psCnt <= psCnt + 1'b1;
        end
      end

      if (resetMode && (underflow || strb.violate)) wdReset <= 1'b1;

      if (underflow && !resetMode) ovfFlag <= 1'b1;
      else if (strb.clrFlag)       ovfFlag <= 1'b0;
    end
  end

  assign irq = ovfFlag && irqEn;

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdt_pkg::*;
#(
  parameter int                DATA_W   = 8,
  parameter int                PRE_W    = 3,
  parameter int                FIX_LOG2 = 5,
  parameter logic [DATA_W-1:0] KEY1     = 8'hA5,
  parameter logic [DATA_W-1:0] KEY2     = 8'h5A
) (
  input  logic              clk,
  input  logic              rstPor_n,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              otherWr,
  output logic              wdReset,
  output logic              ovfFlag,
  output logic              irq
);

  wdtStrobe_t        strb;
  logic [DATA_W-1:0] loadVal;
  logic              resetMode;
  logic              irqEn;
  logic [PRE_W-1:0]  preSel;

  wdt_feed_ctrl #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .KEY1(KEY1), .KEY2(KEY2)
  ) u_ctrl (
    .clk(clk), .rstPor_n(rstPor_n), .tickEn(tickEn),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .otherWr(otherWr),
    .strb(strb), .loadVal(loadVal), .resetMode(resetMode),
    .irqEn(irqEn), .preSel(preSel)
  );

  wdt_count_path #(
    .DATA_W(DATA_W), .PRE_W(PRE_W), .FIX_LOG2(FIX_LOG2)
  ) u_path (
    .clk(clk), .rstPor_n(rstPor_n), .strb(strb), .loadVal(loadVal),
    .resetMode(resetMode), .irqEn(irqEn), .preSel(preSel),
    .wdReset(wdReset), .ovfFlag(ovfFlag), .irq(irq)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic       clk,
  input logic       rstPor_n,
  input logic       tickEn,
  input logic       wdReset,
  input logic       ovfFlag,
  input logic       irq,
  input wdtStrobe_t strb,
  input logic       resetMode
);

  p_reset_hold_r10: assert property (@(posedge clk) disable iff (!rstPor_n)
    wdReset |=> wdReset);

  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rstPor_n)
    irq |-> ovfFlag);

  p_violation_resets_r5: assert property (@(posedge clk) disable iff (!rstPor_n)
    (strb.violate && resetMode) |=> wdReset);

  p_idle_clock_r4: assert property (@(posedge clk) disable iff (!rstPor_n)
    (!tickEn && !strb.violate) |=> ($stable(wdReset) && !$rose(ovfFlag)));

  p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rstPor_n)
    resetMode |=> resetMode);

  p_timer_no_reset_r11: assert property (@(posedge clk) disable iff (!rstPor_n)
    !resetMode |=> !$rose(wdReset));

  p_reload_quiet_r2: assert property (@(posedge clk) disable iff (!rstPor_n)
    strb.reload |=> (!$rose(wdReset) && !$rose(ovfFlag)));

endmodule

bind keyed_watchdog wdt_checker u_wdtChk (
  .clk(clk), .rstPor_n(rstPor_n), .tickEn(tickEn), .wdReset(wdReset),
  .ovfFlag(ovfFlag), .irq(irq), .strb(strb), .resetMode(resetMode)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;

  logic       clk = 1'b0;
  logic       rstPor_n = 1'b0;
  logic       tickEn = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic       otherWr = 1'b0;
  logic       wdReset, ovfFlag, irq;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;
  int  n;

  localparam int LIMIT = 70000;

  typedef struct packed {
    logic [2:0]  pre;
    logic [7:0]  wdl;
    logic [31:0] ticks;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{3'd0, 8'd0,   32'd33},
    '{3'd0, 8'd1,   32'd65},
    '{3'd1, 8'd0,   32'd65},
    '{3'd2, 8'd3,   32'd513},
    '{3'd4, 8'd2,   32'd1537},
    '{3'd7, 8'd0,   32'd4097},
    '{3'd3, 8'd255, 32'd65537}
  };

  keyed_watchdog u_keyed_watchdog (
    .clk(clk), .rstPor_n(rstPor_n), .tickEn(tickEn), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .otherWr(otherWr),
    .wdReset(wdReset), .ovfFlag(ovfFlag), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk);
    rstPor_n = 1'b0; wrEn = 1'b0; otherWr = 1'b0; tickEn = 1'b1;
    repeat (3) @(negedge clk);
    rstPor_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseOther();
    @(negedge clk);
    otherWr = 1'b1;
    @(negedge clk);
    otherWr = 1'b0;
  endtask

  task automatic feed();
    regWrite(2'd2, 8'hA5);
    regWrite(2'd3, 8'h5A);
  endtask

  task automatic measure(input bit watchReset, output int cnt);
    cnt = 0;
    while (cnt < LIMIT) begin
      @(posedge clk); #1;
      cnt++;
      if (watchReset ? wdReset : ovfFlag) break;
    end
  endtask

  // watchdog mode, slowest setting, so no timeout during short tests
  task automatic armSlowReset();
    por();
    regWrite(2'd1, 8'hFF);
    regWrite(2'd0, 8'h73);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual 1 expected 0 (run hung)");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    por();
    // R1 reset state
    checkEq("R1 wdReset", int'(wdReset), 0);
    checkEq("R1 ovfFlag", int'(ovfFlag), 0);
    checkEq("R1 irq", int'(irq), 0);

    // R3 / R9 table in timer mode with irq enabled
    foreach (VEC[i]) begin
      regWrite(2'd1, VEC[i].wdl);
      regWrite(2'd0, {1'b0, VEC[i].pre, 4'b1101});
      feed();
      checkEq("R9 flag cleared", int'(ovfFlag), 0);
      measure(1'b0, n);
      checkEq($sformatf("R3 timeout pre=%0d load=%0d", VEC[i].pre, VEC[i].wdl), n, int'(VEC[i].ticks));
      checkEq("R9 irq with enable", int'(irq), 1);
      checkEq("R9 no reset in timer mode", int'(wdReset), 0);
    end

    // R4 tick gating
    por();
    regWrite(2'd1, 8'd0);
    regWrite(2'd0, 8'h05);
    feed();
    tickEn = 1'b0;
    repeat (200) @(negedge clk);
    checkEq("R4 no advance without tick", int'(ovfFlag), 0);
    tickEn = 1'b1;
    measure(1'b0, n);
    checkEq("R4 tick count", n, 33);
    checkEq("R9 irq set", int'(irq), 1);
    // R9 clear and irq gating, periodic reload
    regWrite(2'd0, 8'h09);
    checkEq("R9 flag cleared by write", int'(ovfFlag), 0);
    checkEq("R9 irq cleared", int'(irq), 0);
    measure(1'b0, n);
    checkEq("R9 periodic flag again", int'(ovfFlag), 1);
    checkEq("R9 irq gated off", int'(irq), 0);
    checkEq("R9 still no reset", int'(wdReset), 0);

    // R7 shadow takes effect one tick late
    por();
    tickEn = 1'b0;
    regWrite(2'd0, 8'h01);
    feed();
    repeat (5) @(negedge clk);
    tickEn = 1'b1;
    measure(1'b0, n);
    checkEq("R7 shadow delay", n, 34);

    // R2 / R3 / R10 watchdog mode
    por();
    regWrite(2'd1, 8'd3);
    regWrite(2'd0, 8'h03);
    feed();
    repeat (100) @(negedge clk);
    feed();
    repeat (100) @(negedge clk);
    feed();
    checkEq("R2 fed in time, no reset", int'(wdReset), 0);
    measure(1'b1, n);
    checkEq("R3 watchdog timeout", n, 129);
    repeat (20) @(negedge clk);
    feed();
    checkEq("R10 reset sticky", int'(wdReset), 1);

    // R8 mode cannot be cleared nor stopped
    por();
    regWrite(2'd1, 8'd0);
    regWrite(2'd0, 8'h03);
    regWrite(2'd0, 8'h00);
    feed();
    measure(1'b1, n);
    checkEq("R8 sticky mode timeout", n, 33);

    // R5 interleaved writes
    armSlowReset();
    regWrite(2'd2, 8'hA5);
    checkEq("R5 armed no reset", int'(wdReset), 0);
    pulseOther();
    checkEq("R5 other write", int'(wdReset), 1);
    armSlowReset();
    regWrite(2'd2, 8'hA5);
    regWrite(2'd1, 8'd10);
    checkEq("R5 load write between keys", int'(wdReset), 1);

    // R6 wrong values
    armSlowReset();
    regWrite(2'd2, 8'hA4);
    checkEq("R6 bad key1", int'(wdReset), 1);
    armSlowReset();
    regWrite(2'd3, 8'h5A);
    checkEq("R6 key2 alone", int'(wdReset), 1);
    armSlowReset();
    regWrite(2'd2, 8'hA5);
    regWrite(2'd3, 8'h5B);
    checkEq("R6 bad key2", int'(wdReset), 1);
    armSlowReset();
    feed();
    repeat (5) @(negedge clk);
    checkEq("R2 good pair no reset", int'(wdReset), 0);

    // R11 violations ignored in timer mode
    por();
    regWrite(2'd1, 8'hFF);
    regWrite(2'd0, 8'h71);
    regWrite(2'd2, 8'hA5);
    pulseOther();
    regWrite(2'd3, 8'hA4);
    repeat (5) @(negedge clk);
    checkEq("R11 no reset", int'(wdReset), 0);
    checkEq("R11 no flag", int'(ovfFlag), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule